// File: doc/BRIEF.md
# LIN Frame Command Sequencer with Response Timeout

This block takes a LIN frame command as a series of byte writes to a single command port. Each byte is read according to its place in the series and the frame direction set by the second byte. Once the fourth byte is in, the block asks for a frame header with the captured identifier, direction and length. For a frame sent by this node, the fourth and later bytes go out in order as payload bytes. For a frame whose response comes from a slave, the third and fourth bytes instead form a 12-bit response timeout, in bit times.

The timeout counts bit-time strobes from the start of the break field, reported by the serializer. If the slave has not supplied the full response (the data bytes plus the checksum byte) when the count runs out, a sticky no-response error is raised. Received bytes are held in a receive register guarded by a ready flag. A byte that lands while the flag is still set raises an overrun. A frame-done pulse resets the byte position, so the next write begins a new command.

Top module: `lin_cmd_seq`

## Requirements
- R1: The first byte written is the frame identifier. In the second byte, bit 7 is the direction (1 = slave responds, 0 = node sends) and bits 3:0 are the data length. One cycle after the fourth write, `hdr_go` pulses for one cycle with `hdr_id`, `hdr_rx` and `hdr_len` holding the captured values.
- R2: In a send frame, the fourth and later written bytes appear on `tx_data`, with a one-cycle `tx_vld` pulse one cycle after each write, up to the data length. Writes beyond that length produce no `tx_vld`.
- R3: In a receive frame, bits 3:0 of the third byte are timeout bits 11:8 and the fourth byte is timeout bits 7:0. Bits 7:4 of the third byte are ignored. No written byte of a receive frame produces `tx_vld`.
- R4: The timeout counts `bit_tick` strobes only after a `brk_start` pulse that follows `hdr_go`. Strobes before the break do not count.
- R5: With timeout T, `no_resp_err` reads 1 one cycle after the T-th counted strobe if fewer than length+1 response bytes have arrived, and still reads 0 after T-1 strobes.
- R6: When length+1 response bytes arrive before the timeout, the count stops and later strobes raise no error.
- R7: A send frame, or a receive frame with timeout 0, never raises `no_resp_err`.
- R8: `no_resp_err` and `rx_ovr` stay set through `frame_done` and clear one cycle after the first byte of the next command is written.
- R9: One cycle after `rx_in_valid`, `rx_rdy` is 1 and `rx_data` holds the byte. One cycle after `rx_rd`, `rx_rdy` is 0, and `rx_data` reads 0 while `rx_rdy` is 0.
- R10: A received byte arriving while `rx_rdy` is set and not being read sets `rx_ovr`, and the new byte replaces the held one.
- R11: `frame_done` returns the byte position to the first byte. A command write in the same cycle as `frame_done` is dropped.
- R12: After reset, `hdr_go`, `tx_vld`, `rx_rdy`, `rx_ovr`, `no_resp_err`, `tx_data` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte |
| frame_done | input | 1 | End-of-frame pulse, resets byte position |
| brk_start | input | 1 | Break field transmission has begun |
| bit_tick | input | 1 | One strobe per bit time |
| rx_in_valid | input | 1 | Received byte strobe from the deserializer |
| rx_in_byte | input | 8 | Received byte |
| rx_rd | input | 1 | Receive register read strobe |
| hdr_go | output | 1 | Header request pulse |
| hdr_id | output | 8 | Frame identifier |
| hdr_rx | output | 1 | Frame direction, 1 = slave responds |
| hdr_len | output | 4 | Data length |
| tx_vld | output | 1 | Payload byte valid pulse |
| tx_data | output | 8 | Payload byte |
| rx_data | output | 8 | Held received byte, 0 when not ready |
| rx_rdy | output | 1 | Receive register ready |
| rx_ovr | output | 1 | Receive overrun, sticky |
| no_resp_err | output | 1 | No-response error, sticky |

## Verification
The command decoder is driven with both directions using identical byte positions. This shows that the fourth byte becomes payload in one case and timeout in the other. Surplus writes are sent past the data length and past the fourth receive byte, to show that they are dropped.

The timeout is tried four ways: with strobes sent before the break, at T-1 and T counted strobes, with a complete response arriving in time, and with a zero value. Together these separate the start-of-count point, the expiry cycle, the completion rule and the disabled case. Receive-register patterns (read between bytes versus two unread bytes) separate normal hand-off from overrun. A write issued together with `frame_done` shows that the dropped byte does not shift the next command's positions.

// File: rtl/lin_seq_pkg.sv
package lin_seq_pkg;
  localparam int BYTE_W = 8;
  // byte positions inside a command
  localparam logic [2:0] POS_ID   = 3'd0;
  localparam logic [2:0] POS_CTRL = 3'd1;
  localparam logic [2:0] POS_TOHI = 3'd2;
  localparam logic [2:0] POS_TOLO = 3'd3;
  localparam logic [2:0] POS_DATA = 3'd4;
  localparam int CTRL_DIR_BIT = 7;

  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_ARMED = 2'd1,
    TMR_RUN   = 2'd2
  } tmr_state_t;
endpackage

// File: rtl/lin_rst_sync.sv
module lin_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/lin_cmd_decode.sv
module lin_cmd_decode
  import lin_seq_pkg::*;
#(
  parameter int TO_W  = 12,
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              frame_done,
  output logic              cmd_start,
  output logic              hdr_go,
  output logic [BYTE_W-1:0] hdr_id,
  output logic              hdr_rx,
  output logic [LEN_W-1:0]  hdr_len,
  output logic [TO_W-1:0]   tmo_val,
  output logic              tx_vld,
  output logic [BYTE_W-1:0] tx_data
);
  localparam int HI_W  = TO_W - BYTE_W;
  localparam int DCN_W = LEN_W + 1;

  logic [2:0]        pos_q, pos_d;
  logic [BYTE_W-1:0] id_q, id_d;
  logic              rx_q, rx_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [TO_W-1:0]   tmo_q, tmo_d;
  logic [DCN_W-1:0]  dcnt_q, dcnt_d;
  logic              go_q, go_d;
  logic              tv_q, tv_d;
  logic [BYTE_W-1:0] td_q, td_d;
  logic              wr_ok;
  logic              can_fwd;

  assign wr_ok     = cmd_wr && !frame_done;
  assign cmd_start = wr_ok && (pos_q == POS_ID);
  assign can_fwd   = !rx_q && (dcnt_q < {1'b0, len_q});

  always_comb begin
    pos_d  = pos_q;
    id_d   = id_q;
    rx_d   = rx_q;
    len_d  = len_q;
    tmo_d  = tmo_q;
    dcnt_d = dcnt_q;
    go_d   = 1'b0;
    tv_d   = 1'b0;
    td_d   = td_q;
    if (frame_done) begin
      pos_d  = POS_ID;
      dcnt_d = '0;
    end else if (cmd_wr) begin
      case (pos_q)
        POS_ID: begin
          id_d  = cmd_byte;
          pos_d = POS_CTRL;
        end
        POS_CTRL: begin
          rx_d   = cmd_byte[CTRL_DIR_BIT];
          len_d  = cmd_byte[LEN_W-1:0];
          tmo_d  = '0;
          dcnt_d = '0;
          pos_d  = POS_TOHI;
        end
        POS_TOHI: begin
          if (rx_q) tmo_d[TO_W-1:BYTE_W] = cmd_byte[HI_W-1:0];
          pos_d = POS_TOLO;
        end
        POS_TOLO: begin
          go_d = 1'b1;
          if (rx_q) tmo_d[BYTE_W-1:0] = cmd_byte;
          if (can_fwd) begin
            tv_d   = 1'b1;
            td_d   = cmd_byte;
            dcnt_d = dcnt_q + 1'b1;
          end
          pos_d = POS_DATA;
        end
        default: begin
          if (can_fwd) begin
            tv_d   = 1'b1;
            td_d   = cmd_byte;
            dcnt_d = dcnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= POS_ID;
      id_q   <= '0;
      rx_q   <= 1'b0;
      len_q  <= '0;
      tmo_q  <= '0;
      dcnt_q <= '0;
      go_q   <= 1'b0;
      tv_q   <= 1'b0;
      td_q   <= '0;
    end else begin
      pos_q  <= pos_d;
      id_q   <= id_d;
      rx_q   <= rx_d;
      len_q  <= len_d;
      tmo_q  <= tmo_d;
      dcnt_q <= dcnt_d;
      go_q   <= go_d;
      tv_q   <= tv_d;
      td_q   <= td_d;
    end
  end

  assign hdr_go  = go_q;
  assign hdr_id  = id_q;
  assign hdr_rx  = rx_q;
  assign hdr_len = len_q;
  assign tmo_val = tmo_q;
  assign tx_vld  = tv_q;
  assign tx_data = td_q;
endmodule

// File: rtl/lin_resp_timer.sv
module lin_resp_timer
  import lin_seq_pkg::*;
#(
  parameter int TO_W  = 12,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_go,
  input  logic             hdr_rx,
  input  logic [LEN_W-1:0] hdr_len,
  input  logic [TO_W-1:0]  tmo_val,
  input  logic             brk_start,
  input  logic             bit_tick,
  input  logic             rx_in_valid,
  input  logic             frame_done,
  input  logic             err_clr,
  output logic             no_resp_err
);
  tmr_state_t       st_q, st_d;
  logic [TO_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0] rcnt_q, rcnt_d;
  logic             err_q, err_d;
  logic             resp_last;
  logic             expire;

  assign resp_last = rx_in_valid && (rcnt_q == hdr_len);
  assign expire    = bit_tick && (cnt_q == {{(TO_W-1){1'b0}}, 1'b1});

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rcnt_d = rcnt_q;
    err_d  = err_q;
    if (err_clr) err_d = 1'b0;
    if (frame_done) begin
      st_d = TMR_IDLE;
    end else begin
      case (st_q)
        TMR_IDLE: begin
          if (hdr_go && hdr_rx && (tmo_val != '0)) st_d = TMR_ARMED;
        end
        TMR_ARMED: begin
          if (brk_start) begin
            st_d   = TMR_RUN;
            cnt_d  = tmo_val;
            rcnt_d = '0;
          end
        end
        TMR_RUN: begin
          if (resp_last) begin
            st_d = TMR_IDLE;
          end else begin
            if (rx_in_valid) rcnt_d = rcnt_q + 1'b1;
            if (expire) begin
              err_d = 1'b1;
              st_d  = TMR_IDLE;
            end else if (bit_tick) begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: st_d = TMR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TMR_IDLE;
      cnt_q  <= '0;
      rcnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rcnt_q <= rcnt_d;
      err_q  <= err_d;
    end
  end

  assign no_resp_err = err_q;
endmodule

// File: rtl/lin_rx_hold.sv
module lin_rx_hold
  import lin_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in_valid,
  input  logic [BYTE_W-1:0] rx_in_byte,
  input  logic              rx_rd,
  input  logic              ovr_clr,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_rdy,
  output logic              rx_ovr
);
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              rdy_q, rdy_d;
  logic              ovr_q, ovr_d;

  always_comb begin
    hold_d = hold_q;
    rdy_d  = rdy_q;
    ovr_d  = ovr_q;
    if (ovr_clr) ovr_d = 1'b0;
    if (rx_in_valid) begin
      hold_d = rx_in_byte;
      rdy_d  = 1'b1;
      if (rdy_q && !rx_rd) ovr_d = 1'b1;
    end else if (rx_rd) begin
      rdy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      rdy_q  <= rdy_d;
      ovr_q  <= ovr_d;
    end
  end

  assign rx_data = rdy_q ? hold_q : '0;
  assign rx_rdy  = rdy_q;
  assign rx_ovr  = ovr_q;
endmodule

// File: rtl/lin_cmd_seq.sv
module lin_cmd_seq
  import lin_seq_pkg::*;
#(
  parameter int TO_W  = 12,
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_byte,
  input  logic              frame_done,
  input  logic              brk_start,
  input  logic              bit_tick,
  input  logic              rx_in_valid,
  input  logic [7:0]        rx_in_byte,
  input  logic              rx_rd,
  output logic              hdr_go,
  output logic [7:0]        hdr_id,
  output logic              hdr_rx,
  output logic [LEN_W-1:0]  hdr_len,
  output logic              tx_vld,
  output logic [7:0]        tx_data,
  output logic [7:0]        rx_data,
  output logic              rx_rdy,
  output logic              rx_ovr,
  output logic              no_resp_err
);
  logic            rst_n_s;
  logic            cmd_start;
  logic [TO_W-1:0] tmo_val;

  lin_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  lin_cmd_decode #(.TO_W(TO_W), .LEN_W(LEN_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cmd_wr     (cmd_wr),
    .cmd_byte   (cmd_byte),
    .frame_done (frame_done),
    .cmd_start  (cmd_start),
    .hdr_go     (hdr_go),
    .hdr_id     (hdr_id),
    .hdr_rx     (hdr_rx),
    .hdr_len    (hdr_len),
    .tmo_val    (tmo_val),
    .tx_vld     (tx_vld),
    .tx_data    (tx_data)
  );

  lin_resp_timer #(.TO_W(TO_W), .LEN_W(LEN_W)) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .hdr_go      (hdr_go),
    .hdr_rx      (hdr_rx),
    .hdr_len     (hdr_len),
    .tmo_val     (tmo_val),
    .brk_start   (brk_start),
    .bit_tick    (bit_tick),
    .rx_in_valid (rx_in_valid),
    .frame_done  (frame_done),
    .err_clr     (cmd_start),
    .no_resp_err (no_resp_err)
  );

  lin_rx_hold u_rxh (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .rx_in_valid (rx_in_valid),
    .rx_in_byte  (rx_in_byte),
    .rx_rd       (rx_rd),
    .ovr_clr     (cmd_start),
    .rx_data     (rx_data),
    .rx_rdy      (rx_rdy),
    .rx_ovr      (rx_ovr)
  );
endmodule

// File: rtl/lin_cmd_seq_chk.sv
module lin_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_wr,
  input logic bit_tick,
  input logic rx_in_valid,
  input logic rx_rd,
  input logic hdr_go,
  input logic hdr_rx,
  input logic tx_vld,
  input logic rx_rdy,
  input logic rx_ovr,
  input logic no_resp_err
);
  a_r1_go_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_go |-> $past(cmd_wr));

  a_r2_tx_only_send: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> !hdr_rx);

  a_r5_err_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_resp_err) |-> $past(bit_tick));

  a_r9_ready_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid |=> rx_rdy);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_in_valid) |=> !rx_rdy);

  a_r10_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> ($past(rx_in_valid) && $past(rx_rdy)));
endmodule

bind lin_cmd_seq lin_cmd_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_wr      (cmd_wr),
  .bit_tick    (bit_tick),
  .rx_in_valid (rx_in_valid),
  .rx_rd       (rx_rd),
  .hdr_go      (hdr_go),
  .hdr_rx      (hdr_rx),
  .tx_vld      (tx_vld),
  .rx_rdy      (rx_rdy),
  .rx_ovr      (rx_ovr),
  .no_resp_err (no_resp_err)
);

// File: tb/sim_lin_cmd_seq.sv
`timescale 1ns/1ps
module sim_lin_cmd_seq;
  logic       clk;
  logic       rst_n;
  logic       cmd_wr;
  logic [7:0] cmd_byte;
  logic       frame_done;
  logic       brk_start;
  logic       bit_tick;
  logic       rx_in_valid;
  logic [7:0] rx_in_byte;
  logic       rx_rd;
  logic       hdr_go;
  logic [7:0] hdr_id;
  logic       hdr_rx;
  logic [3:0] hdr_len;
  logic       tx_vld;
  logic [7:0] tx_data;
  logic [7:0] rx_data;
  logic       rx_rdy;
  logic       rx_ovr;
  logic       no_resp_err;

  int total = 0;
  int fails = 0;

  lin_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .frame_done(frame_done), .brk_start(brk_start), .bit_tick(bit_tick),
    .rx_in_valid(rx_in_valid), .rx_in_byte(rx_in_byte), .rx_rd(rx_rd),
    .hdr_go(hdr_go), .hdr_id(hdr_id), .hdr_rx(hdr_rx), .hdr_len(hdr_len),
    .tx_vld(tx_vld), .tx_data(tx_data), .rx_data(rx_data), .rx_rdy(rx_rdy),
    .rx_ovr(rx_ovr), .no_resp_err(no_resp_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    cmd_wr = 1'b1; cmd_byte = b;
    @(posedge clk); #1;
    cmd_wr = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      @(posedge clk); #1;
      bit_tick = 1'b0;
    end
  endtask

  task automatic brk();
    brk_start = 1'b1;
    @(posedge clk); #1;
    brk_start = 1'b0;
  endtask

  task automatic rxb(input logic [7:0] b);
    rx_in_valid = 1'b1; rx_in_byte = b;
    @(posedge clk); #1;
    rx_in_valid = 1'b0;
  endtask

  task automatic rd();
    rx_rd = 1'b1;
    @(posedge clk); #1;
    rx_rd = 1'b0;
  endtask

  task automatic fdone();
    frame_done = 1'b1;
    @(posedge clk); #1;
    frame_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 hdr_go", hdr_go, 0);
    chk("R12 tx_vld", tx_vld, 0);
    chk("R12 tx_data", tx_data, 0);
    chk("R12 rx_rdy", rx_rdy, 0);
    chk("R12 rx_data", rx_data, 0);
    chk("R12 rx_ovr", rx_ovr, 0);
    chk("R12 no_resp_err", no_resp_err, 0);
  endtask

  task automatic t_send();
    wr(8'h21); wr(8'h02); wr(8'hF3);
    chk("R1 no go before 4th", hdr_go, 0);
    wr(8'hAA);
    chk("R1 hdr_go", hdr_go, 1);
    chk("R1 hdr_id", hdr_id, 8'h21);
    chk("R1 hdr_rx", hdr_rx, 0);
    chk("R1 hdr_len", hdr_len, 2);
    chk("R2 first vld", tx_vld, 1);
    chk("R2 first data", tx_data, 8'hAA);
    wr(8'h55);
    chk("R1 go single", hdr_go, 0);
    chk("R2 second vld", tx_vld, 1);
    chk("R2 second data", tx_data, 8'h55);
    wr(8'h77);
    chk("R2 beyond length", tx_vld, 0);
    idle(); brk(); tick(20);
    chk("R7 send frame no err", no_resp_err, 0);
    fdone();
  endtask

  task automatic t_rx_timeout();
    wr(8'h10); wr(8'h83); wr(8'hA1); wr(8'h02);
    chk("R1 rx go", hdr_go, 1);
    chk("R1 rx dir", hdr_rx, 1);
    chk("R3 4th not payload", tx_vld, 0);
    wr(8'h99);
    chk("R3 extra ignored", tx_vld, 0);
    tick(10);
    brk();
    tick(257);
    chk("R4 pre-break ticks ignored", no_resp_err, 0);
    chk("R5 T-1 no err", no_resp_err, 0);
    tick(1);
    chk("R5 T expiry", no_resp_err, 1);
    fdone();
    chk("R8 err held after done", no_resp_err, 1);
    wr(8'h05);
    chk("R8 err cleared by new cmd", no_resp_err, 0);
    fdone();
  endtask

  task automatic t_rx_complete();
    wr(8'h30); wr(8'h81); wr(8'h00); wr(8'h05);
    idle(); brk(); tick(2);
    rxb(8'h11);
    chk("R9 rdy set", rx_rdy, 1);
    chk("R9 data", rx_data, 8'h11);
    rd();
    chk("R9 rdy cleared", rx_rdy, 0);
    chk("R9 data zero", rx_data, 0);
    rxb(8'h22);
    tick(10);
    chk("R6 complete no err", no_resp_err, 0);
    rd();
    fdone();
  endtask

  task automatic t_rx_zero();
    wr(8'h31); wr(8'h81); wr(8'h00); wr(8'h00);
    idle(); brk(); tick(5);
    chk("R7 zero timeout no err", no_resp_err, 0);
    fdone();
  endtask

  task automatic t_overrun();
    rxb(8'h44);
    chk("R10 no ovr first", rx_ovr, 0);
    rxb(8'h66);
    chk("R10 ovr set", rx_ovr, 1);
    chk("R10 new byte kept", rx_data, 8'h66);
    rd();
    chk("R9 rdy cleared ovr", rx_rdy, 0);
    fdone();
    chk("R8 ovr held", rx_ovr, 1);
    wr(8'h01);
    chk("R8 ovr cleared", rx_ovr, 0);
    fdone();
  endtask

  task automatic t_done_priority();
    wr(8'h12); wr(8'h80);
    frame_done = 1'b1; cmd_wr = 1'b1; cmd_byte = 8'hEE;
    @(posedge clk); #1;
    frame_done = 1'b0; cmd_wr = 1'b0;
    wr(8'h3C); wr(8'h01); wr(8'h00); wr(8'hB7);
    chk("R11 go", hdr_go, 1);
    chk("R11 id from fresh pos", hdr_id, 8'h3C);
    chk("R11 send dir", hdr_rx, 0);
    chk("R11 data", tx_data, 8'hB7);
    fdone();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_byte = '0; frame_done = 1'b0;
    brk_start = 1'b0; bit_tick = 1'b0; rx_in_valid = 1'b0;
    rx_in_byte = '0; rx_rd = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_send();
    t_rx_timeout();
    t_rx_complete();
    t_rx_zero();
    t_overrun();
    t_done_priority();
    summary();
    $finish;
  end
endmodule